// File: doc/BRIEF.md
# Cyclic (7,4) Single-Error-Correcting Codec

The block holds two independent paths that share one package. The encode path takes a 4-bit data word and returns a systematic 7-bit word. The data bits sit in the upper four positions, and the lower three positions hold the remainder of data·x^3 divided by the generator 1 + x + x^3. The decode path takes a received 7-bit word and divides it by the same generator to get a 3-bit syndrome. It then flips the one bit that this syndrome points to, and returns the repaired word, its upper four bits as data, and a flag that shows whether a repair was made.

Both paths run the division on a 3-stage shift-register divider. The divider takes the word most significant bit first, one bit per clock, for seven clocks. On each side, input and output use a valid/ready handshake. A path accepts a new word only after its previous result has been taken. Words with more than one bit in error are not detected as such. They are forced to the nearest codeword that the syndrome names.

Top module: `hamcyc_codec`

## Requirements
- R1: The encoder output has data in bits [6:3] and the remainder of data·x^3 modulo 1 + x + x^3 in bits [2:0]. For example, data 0111 gives 0111010, 1011 gives 1011000, 0001 gives 0001011 and 1111 gives 1111111.
- R2: Every word presented by the encoder is exactly divisible by 1 + x + x^3.
- R3: A received word with zero syndrome is passed through unchanged, with err low and data equal to bits [6:3].
- R4: A single flipped bit is corrected and err is raised. A flip at bit 0 (rightmost) up to bit 6 gives syndromes 001, 010, 100, 011, 110, 111, 101 respectively. For example, 1111010 is repaired to 0111010 with data 0111.
- R5: For any received word, including words with two flipped bits, the decoder output is a codeword, err is high exactly when the syndrome is nonzero, and the data bits are bits [6:3] of that output.
- R6: While out_valid is high and out_ready is low, out_valid stays high and the output fields hold their values, on both paths.
- R7: A path keeps in_ready low from the cycle after it accepts a word until its result has been taken.
- R8: After synchronous reset, both out_valid signals are low and both in_ready signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_in_valid | input | 1 | Data word offered to the encoder |
| enc_in_ready | output | 1 | Encoder can accept a word |
| enc_in_data | input | 4 | Data word to encode |
| enc_out_valid | output | 1 | Encoded word available |
| enc_out_ready | input | 1 | Consumer takes the encoded word |
| enc_out_word | output | 7 | Systematic codeword |
| dec_in_valid | input | 1 | Received word offered to the decoder |
| dec_in_ready | output | 1 | Decoder can accept a word |
| dec_in_word | input | 7 | Received word |
| dec_out_valid | output | 1 | Decoded result available |
| dec_out_ready | input | 1 | Consumer takes the decoded result |
| dec_out_word | output | 7 | Repaired codeword |
| dec_out_data | output | 4 | Recovered data bits |
| dec_out_err | output | 1 | A bit was flipped during repair |

## Verification
The assertions check three things on every clock cycle. Output fields must hold while back-pressured. Each path must refuse input while a result is in flight. Every presented word from either path must be divisible by the generator, and this is computed by long division that does not go through the shift-register divider. Only the bench can show which data maps to which parity bits, that the repaired bit is the correct one for each of the seven positions, and that clean words pass through untouched. It does this with all sixteen data words, a directed repair case, and seeded random mixes of clean, single-error and double-error words.

// File: rtl/cyc74_pkg.sv
package cyc74_pkg;
  localparam int CW_N = 7;
  localparam int CW_K = 4;
  localparam int CW_R = CW_N - CW_K;
  // generator without its leading x^3 term: x + 1
  localparam logic [CW_R-1:0] GEN_TAPS = 3'b011;

  // one step of r = (r*x + b) mod g
  function automatic logic [CW_R-1:0] rem_step(input logic [CW_R-1:0] r, input logic b);
    return {r[CW_R-2:0], b} ^ (r[CW_R-1] ? GEN_TAPS : '0);
  endfunction

  // bit to flip for a syndrome: position p where x^p mod g equals it
  function automatic logic [CW_N-1:0] flip_of_syn(input logic [CW_R-1:0] s);
    logic [CW_R-1:0] pw;
    logic [CW_N-1:0] f;
    pw = {{(CW_R-1){1'b0}}, 1'b1};
    f  = '0;
    for (int p = 0; p < CW_N; p++) begin
      if (s != '0 && pw == s) f[p] = 1'b1;
      pw = rem_step(pw, 1'b0);
    end
    return f;
  endfunction
endpackage

// File: rtl/cyc_lfsr_div.sv
module cyc_lfsr_div
  import cyc74_pkg::*;
#(
  parameter int N = CW_N
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N-1:0]    word,
  output logic            done,
  output logic [CW_R-1:0] rem
);
  localparam int CNTW = $clog2(N + 1);

  logic [N-1:0]    sh;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      cnt  <= '0;
      rem  <= '0;
      done <= 1'b0;
    end else if (start) begin
      sh   <= word;
      cnt  <= CNTW'(N);
      rem  <= '0;
      done <= 1'b0;
    end else if (cnt != '0) begin
      rem  <= rem_step(rem, sh[N-1]);
      sh   <= sh << 1;
      cnt  <= cnt - 1'b1;
      done <= (cnt == CNTW'(1));
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/cyc_encoder.sv
module cyc_encoder
  import cyc74_pkg::*;
#(
  parameter int N = CW_N,
  parameter int K = CW_K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [K-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_word
);
  localparam int R = N - K;

  logic         pend;
  logic [K-1:0] data_q;
  logic         accept;
  logic         div_done;
  logic [R-1:0] div_rem;

  assign in_ready = !pend && !out_valid;
  assign accept   = in_valid && in_ready;

  cyc_lfsr_div #(.N(N)) i_div (
    .clk(clk), .rst(rst), .start(accept),
    .word({in_data, {R{1'b0}}}),
    .done(div_done), .rem(div_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      data_q    <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      if (accept) begin
        pend   <= 1'b1;
        data_q <= in_data;
      end
      if (div_done) begin
        pend      <= 1'b0;
        out_valid <= 1'b1;
        out_word  <= {data_q, div_rem};
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cyc_decoder.sv
module cyc_decoder
  import cyc74_pkg::*;
#(
  parameter int N = CW_N,
  parameter int K = CW_K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_word,
  output logic [K-1:0] out_data,
  output logic         out_err
);
  localparam int R = N - K;

  logic         pend;
  logic [N-1:0] word_q;
  logic         accept;
  logic         div_done;
  logic [R-1:0] syn;
  logic [N-1:0] fixed_w;

  assign in_ready = !pend && !out_valid;
  assign accept   = in_valid && in_ready;

  cyc_lfsr_div #(.N(N)) i_div (
    .clk(clk), .rst(rst), .start(accept),
    .word(in_word), .done(div_done), .rem(syn)
  );

  always_comb fixed_w = word_q ^ flip_of_syn(syn);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      word_q    <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      if (accept) begin
        pend   <= 1'b1;
        word_q <= in_word;
      end
      if (div_done) begin
        pend      <= 1'b0;
        out_valid <= 1'b1;
        out_word  <= fixed_w;
        out_data  <= fixed_w[N-1:R];
        out_err   <= (syn != '0);
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hamcyc_codec.sv
module hamcyc_codec
  import cyc74_pkg::*;
#(
  parameter int N = CW_N,
  parameter int K = CW_K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enc_in_valid,
  output logic         enc_in_ready,
  input  logic [K-1:0] enc_in_data,
  output logic         enc_out_valid,
  input  logic         enc_out_ready,
  output logic [N-1:0] enc_out_word,
  input  logic         dec_in_valid,
  output logic         dec_in_ready,
  input  logic [N-1:0] dec_in_word,
  output logic         dec_out_valid,
  input  logic         dec_out_ready,
  output logic [N-1:0] dec_out_word,
  output logic [K-1:0] dec_out_data,
  output logic         dec_out_err
);
  cyc_encoder #(.N(N), .K(K)) i_enc (
    .clk(clk), .rst(rst),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_data(enc_in_data),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready), .out_word(enc_out_word)
  );

  cyc_decoder #(.N(N), .K(K)) i_dec (
    .clk(clk), .rst(rst),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready), .in_word(dec_in_word),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready), .out_word(dec_out_word),
    .out_data(dec_out_data), .out_err(dec_out_err)
  );
endmodule

// File: rtl/hamcyc_codec_chk.sv
module hamcyc_codec_chk #(
  parameter int N = 7,
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         enc_in_valid,
  input logic         enc_in_ready,
  input logic [K-1:0] enc_in_data,
  input logic         enc_out_valid,
  input logic         enc_out_ready,
  input logic [N-1:0] enc_out_word,
  input logic         dec_in_valid,
  input logic         dec_in_ready,
  input logic [N-1:0] dec_in_word,
  input logic         dec_out_valid,
  input logic         dec_out_ready,
  input logic [N-1:0] dec_out_word,
  input logic [K-1:0] dec_out_data,
  input logic         dec_out_err
);
  localparam logic [3:0] GEN_FULL = 4'b1011;

  // long division by 1011, separate from the shift-register divider
  function automatic logic [2:0] ldiv(input logic [N-1:0] w);
    logic [N-1:0] v;
    v = w;
    for (int i = N - 1; i >= 3; i--)
      if (v[i]) v = v ^ (N'(GEN_FULL) << (i - 3));
    return v[2:0];
  endfunction

  logic [2:0] enc_rem, dec_rem;
  always_comb enc_rem = ldiv(enc_out_word);
  always_comb dec_rem = ldiv(dec_out_word);

  p_enc_codeword_r2: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid |-> enc_rem == 3'b000);
  p_dec_codeword_r5: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid |-> dec_rem == 3'b000);
  p_enc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_word));
  p_dec_hold_r6: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_word)
      && $stable(dec_out_data) && $stable(dec_out_err));
  p_enc_busy_r7: assert property (@(posedge clk) disable iff (rst)
    enc_in_valid && enc_in_ready |=> !enc_in_ready);
  p_dec_busy_r7: assert property (@(posedge clk) disable iff (rst)
    dec_in_valid && dec_in_ready |=> !dec_in_ready);
  p_enc_noinput_r7: assert property (@(posedge clk) disable iff (rst)
    enc_out_valid |-> !enc_in_ready);
  p_dec_noinput_r7: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid |-> !dec_in_ready);
endmodule

bind hamcyc_codec hamcyc_codec_chk #(.N(N), .K(K)) i_chk (
  .clk(clk), .rst(rst),
  .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
  .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_word(enc_out_word),
  .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_word(dec_in_word),
  .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_word(dec_out_word),
  .dec_out_data(dec_out_data), .dec_out_err(dec_out_err)
);

// File: tb/test_hamcyc_codec.sv
`timescale 1ns/1ps
module test_hamcyc_codec;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_in_valid = 1'b0, enc_in_ready, enc_out_valid, enc_out_ready = 1'b0;
  logic [3:0] enc_in_data = '0;
  logic [6:0] enc_out_word;
  logic       dec_in_valid = 1'b0, dec_in_ready, dec_out_valid, dec_out_ready = 1'b0, dec_out_err;
  logic [6:0] dec_in_word = '0, dec_out_word;
  logic [3:0] dec_out_data;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  hamcyc_codec i_hamcyc_codec (
    .clk(clk), .rst(rst),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_word(enc_out_word),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_word(dec_in_word),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_word(dec_out_word),
    .dec_out_data(dec_out_data), .dec_out_err(dec_out_err)
  );

  function automatic logic [2:0] ref_rem(input logic [6:0] w);
    logic [6:0] v;
    v = w;
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b0001011 << (i - 3));
    return v[2:0];
  endfunction

  function automatic logic [6:0] ref_enc(input logic [3:0] d);
    return {d, ref_rem({d, 3'b000})};
  endfunction

  function automatic logic [6:0] ref_fix(input logic [6:0] w);
    logic [6:0] f;
    f = '0;
    for (int p = 0; p < 7; p++)
      if (ref_rem(w) != 3'b000 && ref_rem(7'd1 << p) == ref_rem(w)) f[p] = 1'b1;
    return w ^ f;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enc_run(input logic [3:0] d, input int stall);
    logic [6:0] w0;
    logic [6:0] exp_w;
    bit stable_ok;
    exp_w = ref_enc(d);
    @(negedge clk);
    enc_in_data = d; enc_in_valid = 1'b1;
    while (!enc_in_ready) @(negedge clk);
    @(negedge clk);
    enc_in_valid = 1'b0;
    chk(!enc_in_ready, "R7 enc ready low after accept", 32'(enc_in_ready), 0);
    while (!enc_out_valid) @(negedge clk);
    w0 = enc_out_word; stable_ok = 1'b1;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      if (!enc_out_valid || enc_out_word != w0 || enc_in_ready) stable_ok = 1'b0;
    end
    if (stall > 0) chk(stable_ok, "R6 enc hold under stall", 32'(enc_out_word), 32'(w0));
    chk(enc_out_word == exp_w, "R1 enc word", 32'(enc_out_word), 32'(exp_w));
    chk(ref_rem(enc_out_word) == 3'b000, "R2 enc divisible", 32'(ref_rem(enc_out_word)), 0);
    enc_out_ready = 1'b1;
    @(negedge clk);
    enc_out_ready = 1'b0;
    chk(!enc_out_valid && enc_in_ready, "R7 enc free after take", 32'({enc_out_valid, enc_in_ready}), 1);
  endtask

  task automatic dec_run(input logic [6:0] w, input int stall, input string req);
    logic [6:0] exp_w;
    logic [6:0] w0;
    bit stable_ok;
    exp_w = ref_fix(w);
    @(negedge clk);
    dec_in_word = w; dec_in_valid = 1'b1;
    while (!dec_in_ready) @(negedge clk);
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk(!dec_in_ready, "R7 dec ready low after accept", 32'(dec_in_ready), 0);
    while (!dec_out_valid) @(negedge clk);
    w0 = dec_out_word; stable_ok = 1'b1;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      if (!dec_out_valid || dec_out_word != w0 || dec_in_ready) stable_ok = 1'b0;
    end
    if (stall > 0) chk(stable_ok, "R6 dec hold under stall", 32'(dec_out_word), 32'(w0));
    chk(dec_out_word == exp_w, {req, " dec word"}, 32'(dec_out_word), 32'(exp_w));
    chk(dec_out_data == exp_w[6:3], {req, " dec data"}, 32'(dec_out_data), 32'(exp_w[6:3]));
    chk(dec_out_err == (ref_rem(w) != 3'b000), {req, " dec err"}, 32'(dec_out_err),
        32'(ref_rem(w) != 3'b000));
    dec_out_ready = 1'b1;
    @(negedge clk);
    dec_out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(!enc_out_valid && !dec_out_valid, "R8 out_valid low", 32'({enc_out_valid, dec_out_valid}), 0);
    chk(enc_in_ready && dec_in_ready, "R8 in_ready high", 32'({enc_in_ready, dec_in_ready}), 3);
    // R1 directed values and all data words
    chk(ref_enc(4'b0111) == 7'b0111010 && ref_enc(4'b1011) == 7'b1011000 &&
        ref_enc(4'b0001) == 7'b0001011 && ref_enc(4'b1111) == 7'b1111111,
        "R1 reference table", 0, 0);
    for (int d = 0; d < 16; d++) enc_run(4'(d), d % 3);
    // R4 directed repair of the leftmost bit
    dec_run(7'b1111010, 2, "R4");
    chk(dec_out_word == 7'b0111010 && dec_out_data == 4'b0111, "R4 directed 1111010",
        32'(dec_out_word), 32'h3a);
    // R4 every single-bit position on one codeword
    for (int p = 0; p < 7; p++) dec_run(ref_enc(4'b1010) ^ (7'd1 << p), 0, "R4");
    // random mix: clean R3, single R4, double R5
    for (int it = 0; it < 150; it++) begin
      logic [6:0] cw;
      int mode, p1, p2;
      cw   = ref_enc(4'($urandom % 16));
      mode = int'($urandom % 3);
      p1   = int'($urandom % 7);
      p2   = (p1 + 1 + int'($urandom % 6)) % 7;
      if (mode == 0)      dec_run(cw, int'($urandom % 3), "R3");
      else if (mode == 1) dec_run(cw ^ (7'd1 << p1), int'($urandom % 3), "R4");
      else begin
        dec_run(cw ^ (7'd1 << p1) ^ (7'd1 << p2), int'($urandom % 3), "R5");
        chk(ref_rem(dec_out_word) == 3'b000, "R5 double-error output is codeword",
            32'(ref_rem(dec_out_word)), 0);
      end
      if (it % 10 == 0) enc_run(4'($urandom % 16), int'($urandom % 4));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule